// File: doc/BRIEF.md
# High-Speed PHY Configuration Loader

This block brings up the configuration port of a high-speed USB PHY once the PHY has left reset. A start pulse makes it capture two 32-bit default configuration words. When both words are zero it finishes at once. Otherwise it asks a fuse or NVM port for three analog trim codes: a termination code, a transmit-select code and a current code. It merges those codes into configuration word 0, writes word 0 and then word 1 over a simple register write bus, and finishes with an ordered list of indirect parameter writes. Each parameter write is tunnelled through configuration word 1 with an address strobe and then a data strobe.

The trim codes are used only when the NVM read carried no error and at least one code is nonzero. An all-zero set means the fuses were never programmed, and the block then keeps the default fields and forces a safe disconnect threshold instead. The write bus uses valid/ready. The block raises `wr_valid` and holds `wr_addr`/`wr_data` steady until the cycle in which `wr_ready` is high. Every such cycle transfers exactly one write, and the next write appears no earlier than the following cycle. The NVM port is a request with a one-cycle `nvm_valid` answer.

Top module: `phy_cfg_loader`

## Requirements
- R1: A synchronous reset, applied at any time, returns the block to idle with `done`, `wr_valid` and `nvm_req` low.
- R2: A `start` accepted while idle or done captures `def_cfg0`/`def_cfg1`; later changes on those inputs have no effect on the run. If either word is nonzero, `nvm_req` rises and stays high until the cycle after `nvm_valid` is seen.
- R3: When `nvm_err` is low and any trim code is nonzero, word 0 equals the default with `icur_trim` in bits 31:28, `tsel_trim` in bits 15:12 and `term_trim` in bits 7:6, and every other bit unchanged.
- R4: When `nvm_err` is high or all three trim codes are zero, word 0 equals the default with bits 27:26 forced to 2'b11 and every other bit unchanged.
- R5: The writes appear in a fixed order: word 0 to offset 0x0, word 1 (its default) to offset 0x4, then four writes to offset 0x4 for each list entry, in list order. Nothing else is written.
- R6: Each indirect step rewrites the last word-1 value written. Step 1 puts the entry address in bits 27:16 and sets bit 28. Step 2 clears bit 28. Step 3 clears the mask bits of the data field (23:16), ORs in the value and sets bit 29. Step 4 clears bit 29.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R8: `done` rises in the cycle after the last write is accepted. It stays high until the next accepted `start`, and it is never high together with `wr_valid` or `nvm_req`.
- R9: If both captured defaults are zero, no NVM request and no write occur, and `done` is high right after the edge that samples `start`.
- R10: A `start` that arrives while the block is busy (waiting on NVM or writing) is ignored, even when it falls in the cycle of the final write acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin the load sequence |
| def_cfg0 | input | 32 | Default configuration word 0 |
| def_cfg1 | input | 32 | Default configuration word 1 |
| nvm_req | output | 1 | Trim read request, high while waiting for NVM |
| nvm_valid | input | 1 | Trim data and error flag are valid this cycle |
| nvm_err | input | 1 | The trim read failed |
| term_trim | input | 2 | Termination trim code |
| tsel_trim | input | 4 | Transmit-select trim code |
| icur_trim | input | 4 | Current trim code |
| wr_valid | output | 1 | Register write is offered |
| wr_ready | input | 1 | Register write is accepted this cycle |
| wr_addr | output | ADDR_W | Register offset of the write |
| wr_data | output | 32 | Register write data |
| done | output | 1 | Sequence complete |

## Verification
The critical overlap is a new `start` landing in the same cycle as the acceptance of the final indirect write. The sequence must finish normally and must not restart. The bench provokes this by holding `wr_ready` low until the last write is offered, then raising `wr_ready` and `start` together. It judges the result by `done` being high the next cycle, `nvm_req` staying low and no extra write appearing. A second overlap is tested too: a `start` pulsed while the NVM request is pending must not disturb the write stream, which is compared entry by entry with a bench-computed sequence under random back-pressure.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int WORD_W = 32;

  // word 0 field positions
  localparam int ICUR_LSB  = 28;
  localparam int ICUR_W    = 4;
  localparam int DISC_LSB  = 26;
  localparam int DISC_W    = 2;
  localparam int TSEL_LSB  = 12;
  localparam int TSEL_W    = 4;
  localparam int TERM_LSB  = 6;
  localparam int TERM_W    = 2;

  // word 1 strobe and field positions
  localparam int DSTB_BIT  = 29;
  localparam int ASTB_BIT  = 28;
  localparam int IADR_LSB  = 16;
  localparam int IADR_W    = 12;
  localparam int IDAT_LSB  = 16;
  localparam int IDAT_W    = 8;

  typedef struct packed {
    logic [ICUR_W-1:0] icur;
    logic [TSEL_W-1:0] tsel;
    logic [TERM_W-1:0] term;
  } trim_t;

  typedef enum logic [1:0] {
    PH_ASET = 2'd0,
    PH_ACLR = 2'd1,
    PH_DSET = 2'd2,
    PH_DCLR = 2'd3
  } iphase_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_NVM  = 3'd1,
    ST_CFG0 = 3'd2,
    ST_CFG1 = 3'd3,
    ST_IND  = 3'd4,
    ST_DONE = 3'd5
  } lstate_t;

endpackage

// File: rtl/cfg_trim_merge.sv
module cfg_trim_merge
  import phy_cfg_pkg::*;
#(
  parameter bit TRIM_EN = 1'b1
) (
  input  logic [WORD_W-1:0] def_word,
  input  trim_t             trim,
  input  logic              trim_err,
  output logic [WORD_W-1:0] merged,
  output logic              applied
);

  localparam logic [WORD_W-1:0] ICUR_M = ((WORD_W)'(1) << ICUR_W) - 1 << ICUR_LSB;
  localparam logic [WORD_W-1:0] TSEL_M = ((WORD_W)'(1) << TSEL_W) - 1 << TSEL_LSB;
  localparam logic [WORD_W-1:0] TERM_M = ((WORD_W)'(1) << TERM_W) - 1 << TERM_LSB;
  localparam logic [WORD_W-1:0] DISC_M = ((WORD_W)'(1) << DISC_W) - 1 << DISC_LSB;

  logic nonzero;
  assign nonzero = |trim;

  generate
    if (TRIM_EN) begin : g_trim
      assign applied = !trim_err && nonzero;
    end else begin : g_notrim
      assign applied = 1'b0;
    end
  endgenerate

  always_comb begin
    if (applied) begin
      merged = def_word & ~(ICUR_M | TSEL_M | TERM_M);
      merged = merged | ((WORD_W)'(trim.icur) << ICUR_LSB)
                      | ((WORD_W)'(trim.tsel) << TSEL_LSB)
                      | ((WORD_W)'(trim.term) << TERM_LSB);
    end else begin
      merged = def_word | DISC_M;
    end
  end

endmodule

// File: rtl/ind_step_gen.sv
module ind_step_gen
  import phy_cfg_pkg::*;
#(
  parameter int                       NUM_PARAMS = 1,
  parameter logic [NUM_PARAMS*12-1:0] PARAM_ADDR = 12'd10,
  parameter logic [NUM_PARAMS*8-1:0]  PARAM_MASK = 8'h60,
  parameter logic [NUM_PARAMS*8-1:0]  PARAM_VAL  = 8'h60,
  localparam int PW     = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1,
  localparam int PSLOTS = 1 << PW
) (
  input  logic [WORD_W-1:0] shadow,
  input  logic [PW-1:0]     pidx,
  input  iphase_t           phase,
  output logic [WORD_W-1:0] word
);

  localparam logic [WORD_W-1:0] ADR_M  = ((WORD_W)'(1) << IADR_W) - 1 << IADR_LSB;
  localparam logic [WORD_W-1:0] ASTB_M = (WORD_W)'(1) << ASTB_BIT;
  localparam logic [WORD_W-1:0] DSTB_M = (WORD_W)'(1) << DSTB_BIT;

  logic [IADR_W-1:0] adr_tab [PSLOTS];
  logic [IDAT_W-1:0] msk_tab [PSLOTS];
  logic [IDAT_W-1:0] val_tab [PSLOTS];

  for (genvar g = 0; g < PSLOTS; g++) begin : g_slot
    if (g < NUM_PARAMS) begin : g_used
      assign adr_tab[g] = PARAM_ADDR[g*IADR_W +: IADR_W];
      assign msk_tab[g] = PARAM_MASK[g*IDAT_W +: IDAT_W];
      assign val_tab[g] = PARAM_VAL[g*IDAT_W +: IDAT_W];
    end else begin : g_pad
      assign adr_tab[g] = '0;
      assign msk_tab[g] = '0;
      assign val_tab[g] = '0;
    end
  end

  logic [IADR_W-1:0] cur_adr;
  logic [IDAT_W-1:0] cur_msk;
  logic [IDAT_W-1:0] cur_val;

  assign cur_adr = adr_tab[pidx];
  assign cur_msk = msk_tab[pidx];
  assign cur_val = val_tab[pidx];

  always_comb begin
    unique case (phase)
      PH_ASET: word = (shadow & ~ADR_M) | ((WORD_W)'(cur_adr) << IADR_LSB) | ASTB_M;
      PH_ACLR: word = shadow & ~ASTB_M;
      PH_DSET: word = (shadow & ~((WORD_W)'(cur_msk) << IDAT_LSB))
                      | ((WORD_W)'(cur_val) << IDAT_LSB) | DSTB_M;
      default: word = shadow & ~DSTB_M;
    endcase
  end

endmodule

// File: rtl/phy_cfg_loader.sv
module phy_cfg_loader
  import phy_cfg_pkg::*;
#(
  parameter int                       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]        OFS_CFG0   = 8'h00,
  parameter logic [ADDR_W-1:0]        OFS_CFG1   = 8'h04,
  parameter bit                       TRIM_EN    = 1'b1,
  parameter int                       NUM_PARAMS = 1,
  parameter logic [NUM_PARAMS*12-1:0] PARAM_ADDR = 12'd10,
  parameter logic [NUM_PARAMS*8-1:0]  PARAM_MASK = 8'h60,
  parameter logic [NUM_PARAMS*8-1:0]  PARAM_VAL  = 8'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       def_cfg0,
  input  logic [31:0]       def_cfg1,
  output logic              nvm_req,
  input  logic              nvm_valid,
  input  logic              nvm_err,
  input  logic [1:0]        term_trim,
  input  logic [3:0]        tsel_trim,
  input  logic [3:0]        icur_trim,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              done
);

  localparam int PW = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(NUM_PARAMS - 1);

  lstate_t           state;
  logic [WORD_W-1:0] def0_q, def1_q, shadow_q;
  trim_t             trim_q;
  logic              err_q;
  logic [PW-1:0]     pidx_q;
  iphase_t           phase_q;

  logic [WORD_W-1:0] cfg0_word, ind_word;
  logic              trim_used;
  logic              accept, can_start, zero_defs;

  cfg_trim_merge #(.TRIM_EN(TRIM_EN)) u_merge (
    .def_word (def0_q),
    .trim     (trim_q),
    .trim_err (err_q),
    .merged   (cfg0_word),
    .applied  (trim_used)
  );

  ind_step_gen #(
    .NUM_PARAMS (NUM_PARAMS),
    .PARAM_ADDR (PARAM_ADDR),
    .PARAM_MASK (PARAM_MASK),
    .PARAM_VAL  (PARAM_VAL)
  ) u_step (
    .shadow (shadow_q),
    .pidx   (pidx_q),
    .phase  (phase_q),
    .word   (ind_word)
  );

  assign wr_valid  = (state == ST_CFG0) || (state == ST_CFG1) || (state == ST_IND);
  assign accept    = wr_valid && wr_ready;
  assign nvm_req   = (state == ST_NVM);
  assign done      = (state == ST_DONE);
  assign can_start = (state == ST_IDLE) || (state == ST_DONE);
  assign zero_defs = (def_cfg0 == '0) && (def_cfg1 == '0);

  always_comb begin
    unique case (state)
      ST_CFG0: begin wr_addr = OFS_CFG0; wr_data = cfg0_word; end
      ST_CFG1: begin wr_addr = OFS_CFG1; wr_data = def1_q;    end
      ST_IND:  begin wr_addr = OFS_CFG1; wr_data = ind_word;  end
      default: begin wr_addr = '0;       wr_data = '0;        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      def0_q   <= '0;
      def1_q   <= '0;
      shadow_q <= '0;
      trim_q   <= '0;
      err_q    <= 1'b1;
      pidx_q   <= '0;
      phase_q  <= PH_ASET;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            def0_q <= def_cfg0;
            def1_q <= def_cfg1;
            trim_q <= '0;
            err_q  <= 1'b1;
            if (zero_defs)    state <= ST_DONE;
            else if (TRIM_EN) state <= ST_NVM;
            else              state <= ST_CFG0;
          end
        end
        ST_NVM: begin
          if (nvm_valid) begin
            trim_q <= '{icur: icur_trim, tsel: tsel_trim, term: term_trim};
            err_q  <= nvm_err;
            state  <= ST_CFG0;
          end
        end
        ST_CFG0: if (accept) state <= ST_CFG1;
        ST_CFG1: begin
          if (accept) begin
            shadow_q <= def1_q;
            pidx_q   <= '0;
            phase_q  <= PH_ASET;
            state    <= ST_IND;
          end
        end
        ST_IND: begin
          if (accept) begin
            shadow_q <= ind_word;
            phase_q  <= iphase_t'(phase_q + 2'd1);
            if (phase_q == PH_DCLR) begin
              if (pidx_q == PLAST) state <= ST_DONE;
              else pidx_q <= pidx_q + PW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: offered write holds while stalled
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R8: completion excludes any bus or NVM activity
  p_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid && !nvm_req);

  // R5: the first write of a run targets word 0
  p_first_cfg0_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid) |-> wr_addr == OFS_CFG0);

  // R2: NVM answer ends the request and starts the writes
  p_nvm_ack_r2: assert property (@(posedge clk) disable iff (rst)
    nvm_req && nvm_valid |=> !nvm_req && wr_valid && wr_addr == OFS_CFG0);

  // R9: zero defaults finish immediately
  p_skip_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_valid && !nvm_req && start && def_cfg0 == '0 && def_cfg1 == '0
    |=> done && !nvm_req && !wr_valid);

  // R10: start during a stalled write changes nothing
  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready && start |=> wr_valid && !nvm_req);

endmodule

// File: tb/tb_phy_cfg_loader.sv
module tb_phy_cfg_loader;

  localparam int NP    = 2;
  localparam int TOTAL = 2 + 4 * NP;
  localparam logic [NP*12-1:0] PA = {12'h005, 12'h00A};
  localparam logic [NP*8-1:0]  PM = {8'h0F, 8'h60};
  localparam logic [NP*8-1:0]  PV = {8'h03, 8'h60};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] def_cfg0 = '0, def_cfg1 = '0;
  logic        nvm_req, nvm_valid = 1'b0, nvm_err = 1'b0;
  logic [1:0]  term_trim = '0;
  logic [3:0]  tsel_trim = '0, icur_trim = '0;
  logic        wr_valid, wr_ready = 1'b0, done;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;

  always #4 clk = ~clk;

  phy_cfg_loader #(
    .NUM_PARAMS(NP), .PARAM_ADDR(PA), .PARAM_MASK(PM), .PARAM_VAL(PV)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .def_cfg0(def_cfg0), .def_cfg1(def_cfg1),
    .nvm_req(nvm_req), .nvm_valid(nvm_valid), .nvm_err(nvm_err),
    .term_trim(term_trim), .tsel_trim(tsel_trim), .icur_trim(icur_trim),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int log_cnt = 0;
  int rdy_mode = 0;
  logic [7:0]  log_a [1024];
  logic [31:0] log_d [1024];
  logic        stall_q = 1'b0;
  logic [7:0]  stall_a;
  logic [31:0] stall_d;
  logic [7:0]  exp_a [TOTAL];
  logic [31:0] exp_d [TOTAL];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // bus monitor and ready driver, away from the rising edge
  always @(negedge clk) begin
    if (rst) begin
      stall_q = 1'b0;
    end else begin
      if (stall_q) begin
        chk("R7 valid held", {31'd0, wr_valid}, 32'd1);
        chk("R7 data held", wr_data, stall_d);
        chk("R7 addr held", {24'd0, wr_addr}, {24'd0, stall_a});
      end
      wr_ready = (rdy_mode == 0) ? 1'($urandom % 2) : (rdy_mode == 2);
      if (wr_valid && wr_ready && log_cnt < 1024) begin
        log_a[log_cnt] = wr_addr;
        log_d[log_cnt] = wr_data;
        log_cnt++;
      end
      stall_q = wr_valid && !wr_ready;
      stall_a = wr_addr;
      stall_d = wr_data;
    end
  end

  function automatic logic [31:0] model_cfg0(logic [31:0] d0, logic err,
                                              logic [1:0] r, logic [3:0] s, logic [3:0] h);
    logic [31:0] w;
    if (!err && (r != 0 || s != 0 || h != 0)) begin
      w = d0;
      w[31:28] = h;
      w[15:12] = s;
      w[7:6]   = r;
    end else begin
      w = d0;
      w[27:26] = 2'b11;
    end
    return w;
  endfunction

  task automatic build_exp(input logic [31:0] d0, input logic [31:0] d1, input logic err,
                           input logic [1:0] r, input logic [3:0] s, input logic [3:0] h);
    logic [31:0] sh;
    exp_a[0] = 8'h00; exp_d[0] = model_cfg0(d0, err, r, s, h);
    exp_a[1] = 8'h04; exp_d[1] = d1;
    sh = d1;
    for (int p = 0; p < NP; p++) begin
      sh[27:16] = PA[p*12 +: 12]; sh[28] = 1'b1;       exp_d[2+4*p] = sh;
      sh[28] = 1'b0;                                   exp_d[3+4*p] = sh;
      sh[23:16] = (sh[23:16] & ~PM[p*8 +: 8]) | PV[p*8 +: 8];
      sh[29] = 1'b1;                                   exp_d[4+4*p] = sh;
      sh[29] = 1'b0;                                   exp_d[5+4*p] = sh;
      for (int k = 0; k < 4; k++) exp_a[2+4*p+k] = 8'h04;
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic pulse_start(input logic [31:0] d0, input logic [31:0] d1);
    tick();
    def_cfg0 = d0; def_cfg1 = d1; start = 1'b1;
    tick();
    start = 1'b0;
    def_cfg0 = $urandom; def_cfg1 = $urandom;   // must not matter (R2)
  endtask

  task automatic serve_nvm(input logic err, input logic [1:0] r, input logic [3:0] s,
                           input logic [3:0] h, input int dly, input bit extra_start);
    int t = 0;
    while (!nvm_req && t < 100) begin tick(); t++; end
    chk("R2 nvm_req raised", {31'd0, nvm_req}, 32'd1);
    for (int i = 0; i < dly; i++) begin
      if (extra_start && i == 0) start = 1'b1;  // busy: ignored (R10)
      tick();
      start = 1'b0;
      chk("R2 nvm_req held", {31'd0, nvm_req}, 32'd1);
    end
    nvm_valid = 1'b1; nvm_err = err; term_trim = r; tsel_trim = s; icur_trim = h;
    tick();
    nvm_valid = 1'b0; nvm_err = $urandom; term_trim = $urandom; tsel_trim = $urandom;
    icur_trim = $urandom;
    chk("R2 nvm_req dropped", {31'd0, nvm_req}, 32'd0);
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 400) begin tick(); t++; end
  endtask

  task automatic compare_run(input int base, input bit trim_ok);
    chk("R5 write count", log_cnt - base, TOTAL);
    for (int i = 0; i < TOTAL; i++) begin
      chk("R5 write offset", {24'd0, log_a[base+i]}, {24'd0, exp_a[i]});
      if (i == 0) chk(trim_ok ? "R3 word0" : "R4 word0", log_d[base], exp_d[0]);
      else if (i == 1) chk("R5 word1", log_d[base+1], exp_d[1]);
      else chk("R6 indirect step", log_d[base+i], exp_d[i]);
    end
  endtask

  task automatic run(input logic [31:0] d0, input logic [31:0] d1, input logic err,
                     input logic [1:0] r, input logic [3:0] s, input logic [3:0] h,
                     input int dly, input bit extra_start);
    int base;
    bit ok;
    ok = !err && (r != 0 || s != 0 || h != 0);
    build_exp(d0, d1, err, r, s, h);
    base = log_cnt;
    pulse_start(d0, d1);
    chk("R8 done cleared by start", {31'd0, done}, 32'd0);
    serve_nvm(err, r, s, h, dly, extra_start);
    wait_done();
    chk("R8 done raised", {31'd0, done}, 32'd1);
    compare_run(base, ok);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (2000) @(posedge clk);
    repeat (148000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    int base;
    repeat (4) tick();
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 wr_valid in reset", {31'd0, wr_valid}, 32'd0);
    rst = 1'b0;
    tick();
    chk("R1 nvm_req idle", {31'd0, nvm_req}, 32'd0);

    // directed: untrimmed (all zero), errored, trimmed, all-ones
    run(32'h92316680, 32'h00000106, 1'b0, 2'd0, 4'd0, 4'd0, 2, 1'b0);
    run(32'h92316680, 32'h00000106, 1'b1, 2'd1, 4'd5, 4'd3, 0, 1'b0);
    run(32'h92316680, 32'h00000106, 1'b0, 2'd1, 4'd5, 4'd3, 1, 1'b0);
    run(32'hFFFFFFFF, 32'h3FFFFFFF, 1'b0, 2'd3, 4'hF, 4'hF, 0, 1'b0);
    run(32'h00000000, 32'h00000001, 1'b0, 2'd0, 4'd0, 4'd1, 0, 1'b0);

    // R8: done persists
    repeat (5) tick();
    chk("R8 done persists", {31'd0, done}, 32'd1);

    // random runs
    for (int n = 0; n < 24; n++) begin
      logic [31:0] d0, d1;
      logic e;
      logic [1:0] r;
      logic [3:0] s, h;
      d0 = $urandom; d1 = $urandom;
      e = ($urandom % 4) == 0;
      if (($urandom % 4) == 0) begin r = 0; s = 0; h = 0; end
      else begin r = $urandom; s = $urandom; h = $urandom; end
      run(d0, d1, e, r, s, h, $urandom % 4, 1'b0);
    end

    // R10: start pulsed while waiting on NVM
    run(32'h12345678, 32'h0000ABCD, 1'b0, 2'd2, 4'd9, 4'd6, 3, 1'b1);

    // R9: zero defaults skip everything
    base = log_cnt;
    rst = 1'b1; tick(); rst = 1'b0;
    pulse_start(32'h0, 32'h0);
    chk("R9 done at once", {31'd0, done}, 32'd1);
    chk("R9 no nvm_req", {31'd0, nvm_req}, 32'd0);
    repeat (8) tick();
    chk("R9 no writes", log_cnt - base, 0);

    // R10: start collides with final write acceptance
    rdy_mode = 1;
    build_exp(32'h92316680, 32'h00000106, 1'b0, 2'd1, 4'd2, 4'd3);
    base = log_cnt;
    pulse_start(32'h92316680, 32'h00000106);
    serve_nvm(1'b0, 2'd1, 4'd2, 4'd3, 0, 1'b0);
    rdy_mode = 0;
    begin
      int t = 0;
      while (!(log_cnt - base == TOTAL - 1 && wr_valid) && t < 400) begin tick(); t++; end
    end
    rdy_mode = 1;
    tick();
    rdy_mode = 2;
    start = 1'b1; def_cfg0 = 32'h1; def_cfg1 = 32'h1;
    tick();
    start = 1'b0;
    rdy_mode = 0;
    chk("R10 collide done", {31'd0, done}, 32'd1);
    chk("R10 collide no restart", {31'd0, nvm_req}, 32'd0);
    repeat (6) tick();
    chk("R10 collide done holds", {31'd0, done}, 32'd1);
    compare_run(base, 1'b1);

    // R1: reset in the middle of the writes
    base = log_cnt;
    pulse_start(32'hA5A5A5A5, 32'h00000777);
    serve_nvm(1'b0, 2'd3, 4'd1, 4'd2, 0, 1'b0);
    begin
      int t = 0;
      while (log_cnt - base < 3 && t < 400) begin tick(); t++; end
    end
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 mid reset done", {31'd0, done}, 32'd0);
    chk("R1 mid reset wr_valid", {31'd0, wr_valid}, 32'd0);
    chk("R1 mid reset nvm_req", {31'd0, nvm_req}, 32'd0);
    run(32'h92316680, 32'h00000106, 1'b0, 2'd2, 4'd4, 4'd8, 1, 1'b0);

    report();
  end

endmodule